// File: doc/BRIEF.md
# Mirrored Work-RAM and I/O Bus Decoder

This block sits on the data side of an 8-bit processor bus with a 16-bit address. It serves a 2 KB work RAM that repeats four times across the bottom 8 KB of the address space. It answers reads of two serial game-controller data ports by itself. It drives a controller latch strobe. Every other access is handed to an external sound-unit port. The block also records the most recent value seen on the data bus. A controller read fills its undriven upper bits from that value, as floating bus lines would.

Requests use a valid/ready handshake. A request is complete on the rising clock edge where `req_valid` and `req_ready` are both high. The requester must hold the address, direction and write data stable while `req_valid` is high and `req_ready` is low. Back-pressure has two sources. The first is the RAM fill that follows reset. The second is a forwarded access whose `snd_ready` is low, because `req_ready` follows `snd_ready` for forwarded addresses. The response side has no back-pressure. `rsp_valid` is high for exactly one cycle after each completed request, and the requester must take `rsp_data` in that cycle.

The sound-unit port uses the same handshake. `snd_valid` is high when a request is forwarded. The address, direction and write data pass straight through. `snd_rdata` is sampled on the completing edge.

Top module: `cpu_bus_decoder`

## Requirements
- R1: Addresses 0x0000 to 0x1FFF select the work RAM. Only address bits 10:0 index the RAM, so the four 2 KB aliases at 0x0000, 0x0800, 0x1000 and 0x1800 reach the same byte.
- R2: After reset is released, the block fills the RAM for exactly 2048 cycles and holds `req_ready` low during that time. Every byte is then 0xFF, except offset 0x008 = 0xF7, 0x009 = 0xEF, 0x00A = 0xDF and 0x00F = 0xBF.
- R3: A read of 0x4016 returns bits 7:6 of the previous bus value in bits 7:6, zero in bits 5:1, and `pad0_bit` (sampled on the completing edge) in bit 0.
- R4: A read of 0x4017 returns bits 7:6 of the previous bus value in bits 7:6, zero in bits 5:1, and `pad1_bit` in bit 0.
- R5: The previous bus value is the data of the most recently completed access: the read data for a read and the write data for a write. This includes an access that completed in the cycle just before. It is 0x00 after reset.
- R6: A write to 0x4016 sets `pad_latch` to bit 0 of the written data from the next cycle onward. No other access changes `pad_latch`.
- R7: Every access outside the RAM window is forwarded on the sound port, except reads of 0x4016 and 0x4017. Writes to 0x4016 and 0x4017 are forwarded as well. RAM accesses and controller reads never raise `snd_valid`.
- R8: While a forwarded request has `snd_ready` low, `req_ready` is low and no response is produced. The request completes on the first edge with `snd_ready` high, and `snd_rdata` from that edge is returned.
- R9: `rsp_valid` is high for exactly the one cycle after each completed request. `rsp_data` carries the read data, or the write data for a write.
- R10: While reset is asserted, `pad_latch` and `rsp_valid` are 0, and `req_ready` stays 0 until the fill ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; starts the RAM fill |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Bus address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Read data or echoed write data |
| pad0_bit | input | 1 | Serial data bit of controller port 0 |
| pad1_bit | input | 1 | Serial data bit of controller port 1 |
| pad_latch | output | 1 | Controller latch strobe level |
| snd_valid | output | 1 | Forwarded access present |
| snd_ready | input | 1 | Sound unit accepts the forwarded access |
| snd_write | output | 1 | Forwarded direction |
| snd_addr | output | 16 | Forwarded address |
| snd_wdata | output | 8 | Forwarded write data |
| snd_rdata | input | 8 | Sound-unit read data |

## Verification
The bench first reads all 2048 RAM offsets through the highest alias. This separates a correct fill pattern from a zero fill or from a marker byte in the wrong place. It then writes every offset through one alias and reads it back through a different one. After that it walks a single location through all four aliases, which exposes any extra address bit in the RAM index. The open-bus merge is tried with previous values that cover all four patterns of bits 7:6, plus values with busy low bits. Each merge follows either a write, a RAM read in the cycle just before, or an idle gap. This tells a correct bypass apart from a stale stored value. The latch is checked with odd and even write data and against writes to other addresses. A stalled sound access checks that the handshake holds.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef struct packed {
    logic ram;       // inside the mirrored RAM window
    logic pad_rd;    // read of a controller data port
    logic pad_sel;   // 0 = port 0, 1 = port 1
    logic latch_wr;  // write to the latch strobe register
    logic fwd;       // handed to the sound-unit port
  } dec_t;

  // Power-on byte of the work RAM at a given offset.
  function automatic logic [7:0] init_byte(input int unsigned off);
    case (off)
      32'h008: init_byte = 8'hF7;
      32'h009: init_byte = 8'hEF;
      32'h00A: init_byte = 8'hDF;
      32'h00F: init_byte = 8'hBF;
      default: init_byte = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/cbd_decode.sv
module cbd_decode
  import cbd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 13,
  parameter logic [ADDR_W-1:0] PAD0_ADDR = 16'h4016,
  parameter logic [ADDR_W-1:0] PAD1_ADDR = 16'h4017
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  output dec_t              dec
);
  localparam int HI_W = ADDR_W - WIN_AW;

  logic in_win, is_p0, is_p1;

  always_comb begin
    in_win       = (addr[ADDR_W-1:WIN_AW] == HI_W'(0));
    is_p0        = (addr == PAD0_ADDR);
    is_p1        = (addr == PAD1_ADDR);
    dec.ram      = in_win;
    dec.pad_rd   = !write && (is_p0 || is_p1);
    dec.pad_sel  = is_p1;
    dec.latch_wr = write && is_p0;
    dec.fwd      = !in_win && !dec.pad_rd;
  end
endmodule

// File: rtl/cbd_ram.sv
module cbd_ram
  import cbd_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_q,
  output logic              busy
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     fill_idx;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [DATA_W-1:0] wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_idx <= '0;
      busy     <= 1'b1;
    end else if (busy) begin
      fill_idx <= fill_idx + 1'b1;
      if (&fill_idx) busy <= 1'b0;
    end
  end

  always_comb begin
    wr_en   = busy || (acc_en && acc_write);
    wr_addr = busy ? fill_idx : acc_addr;
    wr_data = busy ? DATA_W'(init_byte(32'(fill_idx))) : acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      rd_q <= '0;
    else if (acc_en && !acc_write)   rd_q <= mem[acc_addr];
  end
endmodule

// File: rtl/cbd_pad.sv
module cbd_pad #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] OPEN_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_wr,
  input  logic              strobe_bit,
  input  logic              sel,
  input  logic              pad0_bit,
  input  logic              pad1_bit,
  input  logic [DATA_W-1:0] bus_prev,
  output logic [DATA_W-1:0] merged,
  output logic              latch
);
  always_ff @(posedge clk) begin
    if (!rst_n)         latch <= 1'b0;
    else if (strobe_wr) latch <= strobe_bit;
  end

  always_comb begin
    merged = (bus_prev & OPEN_MASK) | DATA_W'(sel ? pad1_bit : pad0_bit);
  end
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
  import cbd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11,
  parameter int WIN_AW = 13,
  parameter logic [ADDR_W-1:0] PAD0_ADDR = 16'h4016,
  parameter logic [ADDR_W-1:0] PAD1_ADDR = 16'h4017,
  parameter logic [DATA_W-1:0] OPEN_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              pad0_bit,
  input  logic              pad1_bit,
  output logic              pad_latch,
  output logic              snd_valid,
  input  logic              snd_ready,
  output logic              snd_write,
  output logic [ADDR_W-1:0] snd_addr,
  output logic [DATA_W-1:0] snd_wdata,
  input  logic [DATA_W-1:0] snd_rdata
);
  dec_t              dec;
  logic              ram_busy;
  logic              accept;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] pad_merged;
  logic [DATA_W-1:0] bus_now;
  logic [DATA_W-1:0] mdr_q;
  logic [DATA_W-1:0] hold_q;
  logic              from_ram_q;

  cbd_decode #(
    .ADDR_W(ADDR_W), .WIN_AW(WIN_AW),
    .PAD0_ADDR(PAD0_ADDR), .PAD1_ADDR(PAD1_ADDR)
  ) i_dec (
    .addr(req_addr), .write(req_write), .dec(dec)
  );

  assign req_ready = !ram_busy && (!dec.fwd || snd_ready);
  assign accept    = req_valid && req_ready;

  assign snd_valid = req_valid && dec.fwd && !ram_busy;
  assign snd_write = req_write;
  assign snd_addr  = req_addr;
  assign snd_wdata = req_wdata;

  cbd_ram #(.AW(RAM_AW), .DATA_W(DATA_W)) i_ram (
    .clk(clk), .rst_n(rst_n),
    .acc_en(accept && dec.ram), .acc_write(req_write),
    .acc_addr(req_addr[RAM_AW-1:0]), .acc_wdata(req_wdata),
    .rd_q(ram_q), .busy(ram_busy)
  );

  // Bus value of the latest completed access, bypassing the register
  // when that access finished in the cycle just before.
  assign rsp_data = from_ram_q ? ram_q : hold_q;
  assign bus_now  = rsp_valid ? rsp_data : mdr_q;

  cbd_pad #(.DATA_W(DATA_W), .OPEN_MASK(OPEN_MASK)) i_pad (
    .clk(clk), .rst_n(rst_n),
    .strobe_wr(accept && dec.latch_wr), .strobe_bit(req_wdata[0]),
    .sel(dec.pad_sel), .pad0_bit(pad0_bit), .pad1_bit(pad1_bit),
    .bus_prev(bus_now), .merged(pad_merged), .latch(pad_latch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      from_ram_q <= 1'b0;
      hold_q     <= '0;
      mdr_q      <= '0;
    end else begin
      rsp_valid <= accept;
      if (rsp_valid) mdr_q <= rsp_data;
      if (accept) begin
        from_ram_q <= dec.ram && !req_write;
        if (req_write)       hold_q <= req_wdata;
        else if (dec.pad_rd) hold_q <= pad_merged;
        else if (dec.fwd)    hold_q <= snd_rdata;
      end
    end
  end
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WIN_AW = 13,
  parameter logic [ADDR_W-1:0] PAD0_ADDR = 16'h4016,
  parameter logic [ADDR_W-1:0] PAD1_ADDR = 16'h4017,
  parameter logic [DATA_W-1:0] OPEN_MASK = 8'hC0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              pad0_bit,
  input logic              pad1_bit,
  input logic              pad_latch,
  input logic              snd_valid,
  input logic              snd_ready,
  input logic              ram_busy
);
  localparam logic [DATA_W-1:0] ZERO_MASK = ~(OPEN_MASK | DATA_W'(1));

  logic acc, lat_wr, p0_rd, p1_rd, in_win;
  assign acc    = req_valid && req_ready;
  assign lat_wr = acc && req_write && (req_addr == PAD0_ADDR);
  assign p0_rd  = acc && !req_write && (req_addr == PAD0_ADDR);
  assign p1_rd  = acc && !req_write && (req_addr == PAD1_ADDR);
  assign in_win = (req_addr[ADDR_W-1:WIN_AW] == '0);

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid); // R9
  AST_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> (rsp_data == $past(req_wdata))); // R9
  AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lat_wr |=> (pad_latch == $past(req_wdata[0]))); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_wr |=> $stable(pad_latch)); // R6
  AST_PAD0_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    p0_rd |=> ((rsp_data[0] == $past(pad0_bit)) && ((rsp_data & ZERO_MASK) == '0))); // R3
  AST_PAD1_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    p1_rd |=> ((rsp_data[0] == $past(pad1_bit)) && ((rsp_data & ZERO_MASK) == '0))); // R4
  AST_PAD_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr == PAD0_ADDR || req_addr == PAD1_ADDR)) |-> !snd_valid); // R7
  AST_RAM_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_win) |-> !snd_valid); // R7
  AST_SND_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_ready) |-> !req_ready); // R8
  AST_FILL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ram_busy |-> !req_ready); // R2
endmodule

bind cpu_bus_decoder cbd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW),
  .PAD0_ADDR(PAD0_ADDR), .PAD1_ADDR(PAD1_ADDR), .OPEN_MASK(OPEN_MASK)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pad0_bit(pad0_bit),
  .pad1_bit(pad1_bit), .pad_latch(pad_latch), .snd_valid(snd_valid),
  .snd_ready(snd_ready), .ram_busy(ram_busy)
);

// File: tb/test_cpu_bus_decoder.sv
`timescale 1ns/1ps
module test_cpu_bus_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        pad0_bit = 1'b0, pad1_bit = 1'b0, pad_latch;
  logic        snd_valid, snd_ready = 1'b1, snd_write;
  logic [15:0] snd_addr;
  logic [7:0]  snd_wdata, snd_rdata = 8'h00;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cpu_bus_decoder i_cpu_bus_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pad0_bit(pad0_bit),
    .pad1_bit(pad1_bit), .pad_latch(pad_latch), .snd_valid(snd_valid),
    .snd_ready(snd_ready), .snd_write(snd_write), .snd_addr(snd_addr),
    .snd_wdata(snd_wdata), .snd_rdata(snd_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_init(input int off);
    if (off == 8)       return 8'hF7;
    else if (off == 9)  return 8'hEF;
    else if (off == 10) return 8'hDF;
    else if (off == 15) return 8'hBF;
    return 8'hFF;
  endfunction

  // Starts at a negedge, ends at the negedge after completion.
  task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] q, output logic sv);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    sv = snd_valid;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid after accept", 32'(rsp_valid), 32'd1);
    q = rsp_data;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] q;
    logic sv;
    int n;
    logic [7:0] vals [7] = '{8'h00, 8'h40, 8'h80, 8'hC0, 8'hFF, 8'h3F, 8'hA5};

    repeat (3) @(negedge clk);
    chk("R10 latch in reset", 32'(pad_latch), 32'd0);
    chk("R10 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    req_addr = 16'h0005;
    #1;
    chk("R10 ready low after reset", 32'(req_ready), 32'd0);
    n = 0;
    while (!req_ready) begin @(negedge clk); #1; n++; end
    chk("R2 fill length", 32'(n), 32'd2048);
    chk("R9 no rsp during fill", 32'(rsp_valid), 32'd0);

    // R5: bus value is 0x00 after reset
    pad0_bit = 1'b1;
    access(1'b0, 16'h4016, 8'h00, q, sv);
    chk("R5 reset bus value", 32'(q), 32'h01);
    chk("R7 pad read not forwarded", 32'(sv), 32'd0);

    // R2: power-on contents, read through the top alias (R1)
    for (int o = 0; o < 2048; o++) begin
      access(1'b0, 16'h1800 + 16'(o), 8'h00, q, sv);
      chk("R2 init byte", 32'(q), 32'(exp_init(o)));
    end

    // R1: write via one alias, read via the next
    for (int o = 0; o < 2048; o++) begin
      access(1'b1, 16'((o % 4) * 16'h0800 + o), 8'((o * 7 + 13) & 8'hFF), q, sv);
      if (o < 4) chk("R7 ram write not forwarded", 32'(sv), 32'd0);
    end
    for (int o = 0; o < 2048; o++) begin
      access(1'b0, 16'(((o + 1) % 4) * 16'h0800 + o), 8'h00, q, sv);
      chk("R1 alias readback", 32'(q), 32'((o * 7 + 13) & 8'hFF));
    end
    access(1'b1, 16'h1923, 8'h6C, q, sv);
    for (int k = 0; k < 4; k++) begin
      access(1'b0, 16'(k * 16'h0800 + 16'h0123), 8'h00, q, sv);
      chk("R1 four aliases", 32'(q), 32'h6C);
    end

    // R3 / R4 / R5: open-bus merge
    for (int i = 0; i < 7; i++) begin
      logic b;
      b = 1'(i & 1);
      pad0_bit = b; pad1_bit = !b;
      access(1'b1, 16'h0010, vals[i], q, sv);
      access(1'b0, 16'h4016, 8'h00, q, sv);
      chk("R3 merge after write", 32'(q), 32'((vals[i] & 8'hC0) | 8'(b)));
      @(negedge clk);
      access(1'b0, 16'h4017, 8'h00, q, sv);
      chk("R4 merge after idle", 32'(q), 32'((vals[i] & 8'hC0) | 8'(!b)));
      access(1'b0, 16'h0010, 8'h00, q, sv);
      chk("R5 ram read", 32'(q), 32'(vals[i]));
      access(1'b0, 16'h4017, 8'h00, q, sv);
      chk("R5 merge after ram read", 32'(q), 32'((vals[i] & 8'hC0) | 8'(!b)));
      chk("R7 pad1 read not forwarded", 32'(sv), 32'd0);
    end

    // R6 / R7: latch strobe
    access(1'b1, 16'h4016, 8'h01, q, sv);
    chk("R6 latch set", 32'(pad_latch), 32'd1);
    chk("R7 latch write forwarded", 32'(sv), 32'd1);
    access(1'b1, 16'h4016, 8'hFE, q, sv);
    chk("R6 latch cleared by bit0", 32'(pad_latch), 32'd0);
    access(1'b1, 16'h4016, 8'h03, q, sv);
    repeat (3) @(negedge clk);
    chk("R6 latch holds idle", 32'(pad_latch), 32'd1);
    access(1'b1, 16'h0016, 8'h00, q, sv);
    chk("R6 ram write keeps latch", 32'(pad_latch), 32'd1);
    access(1'b1, 16'h4017, 8'h00, q, sv);
    chk("R6 0x4017 write keeps latch", 32'(pad_latch), 32'd1);
    chk("R7 0x4017 write forwarded", 32'(sv), 32'd1);

    // R8: stalled sound read
    snd_ready = 1'b0;
    snd_rdata = 8'h5A;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h4015;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R8 ready low in stall", 32'(req_ready), 32'd0);
      chk("R7 forwarded valid", 32'(snd_valid), 32'd1);
      chk("R7 forwarded addr", 32'(snd_addr), 32'h4015);
      @(negedge clk);
      chk("R8 no rsp in stall", 32'(rsp_valid), 32'd0);
    end
    snd_ready = 1'b1;
    #1;
    chk("R8 ready follows snd_ready", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 rsp after stall", 32'(rsp_valid), 32'd1);
    chk("R8 snd data returned", 32'(rsp_data), 32'h5A);
    @(negedge clk);
    chk("R9 single rsp pulse", 32'(rsp_valid), 32'd0);
    access(1'b0, 16'h4016, 8'h00, q, sv);
    chk("R3 merge after snd read", 32'(q), 32'h40 | 32'(pad0_bit));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule